// File: doc/BRIEF.md
# Two-Phase Transition-Signalled Pipeline Stage

This block is a single stage of a bundled-data pipeline in which every handshake wire carries meaning only when it changes level. A rising edge and a falling edge each count as one event, and no wire returns to zero. Upstream, a sender places a data bundle on `upData` and then toggles `upReq`. The stage answers by toggling `upAck`. Downstream, the stage presents its held word on `dnData` and toggles `dnReq`. The receiver answers by toggling `dnAck`.

Inside the stage, a Muller C-element decides when a new item may be captured. It waits until a fresh upstream request has arrived and the previous downstream item has been acknowledged. A capture strobe closes the stage register. Once the hold has completed, a capture-done event toggles `upAck` and `dnReq` together. A downstream acknowledge then raises a pass strobe. The pass strobe reopens the register, and a pass-done event frees the stage for the next item.

The design runs in one sampling clock domain. It detects events by comparing the level of each handshake wire with the phase the stage last produced.

Top module: `tpStage`

## Requirements
- R1: After reset, `upAck` and `dnReq` are 0, the stage is empty, and the register is transparent, so `dnData` equals `upData`.
- R2: A capture needs two conditions. First, an upstream request event must be pending, meaning `upReq` differs from `upAck`. Second, the previous downstream item must be acknowledged, meaning `dnAck` equals `dnReq`. A rising and a falling request are treated the same way.
- R3: When a request event reaches an empty stage, the capture happens on the first clock edge. `upAck` and `dnReq` then toggle together on the second edge, and `dnData` shows the word that was on `upData` at capture.
- R4: While `dnReq` differs from `dnAck`, `dnData` stays stable whatever happens on `upData`.
- R5: After a `dnAck` event, the register becomes transparent on the first clock edge, so `dnData` follows `upData` again.
- R6: A change on `upData` with no request event does not toggle `upAck` or `dnReq`.
- R7: A request that arrives while the stage is full waits for the downstream acknowledge. It is captured on the third edge after the `dnAck` event and acknowledged on the fourth.
- R8: Under random delays on both sides, items leave the stage in the order they entered, with none lost and none duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| upReq | input | 1 | Upstream request; each toggle offers one item |
| upData | input | DATA_W | Upstream data bundle |
| upAck | output | 1 | Upstream acknowledge; toggles once the item is held |
| dnReq | output | 1 | Downstream request; toggles when a held item is offered |
| dnData | output | DATA_W | Downstream data bundle |
| dnAck | input | 1 | Downstream acknowledge; each toggle releases the held item |

## Verification
The bench drives inputs just after a falling clock edge and reads outputs at later falling edges, so it can count exactly how many rising edges each result needs. For a request into an empty stage, the acknowledge pair is checked still unchanged one edge later and toggled two edges later. For a request that arrives while the stage is full, the pair is checked unchanged three edges after the downstream acknowledge and toggled on the fourth. Transparency after a pass is checked one edge after the acknowledge. In the random phase, the consumer only waits for toggles, so the checks depend on ordering rather than on timing. Throughout that phase the consumer compares every item with a sequence function and watches `dnData` for stability while each item is outstanding.

// File: rtl/tpStagePkg.sv
package tpStagePkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic pass;
  } stageStrobe_t;

  // completion events from datapath back to control
  typedef struct packed {
    logic captureDone;
    logic passDone;
  } stageDone_t;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_CAPT  = 2'd1,
    ST_FULL  = 2'd2,
    ST_PASS  = 2'd3
  } stageState_t;

endpackage

// File: rtl/tpCElement.sv
module tpCElement #(
  parameter int NIN = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           en,
  input  logic [NIN-1:0] in,
  output logic           fire,
  output logic           cOut
);

  logic [NIN-1:0] moved;

  // an input has moved when its level differs from the last output phase
  for (genvar g = 0; g < NIN; g++) begin : g_moved
    assign moved[g] = in[g] ^ cOut;
  end

  always_comb fire = en & (&moved);

  always_ff @(posedge clk) begin
    if (!rstN) cOut <= 1'b0;
    else       cOut <= cOut ^ fire;
  end

endmodule

// File: rtl/tpStageCtrl.sv
module tpStageCtrl
  import tpStagePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         upReq,
  input  logic         dnAck,
  input  stageDone_t   done,
  output stageStrobe_t stb,
  output logic         upAck,
  output logic         dnReq
);

  localparam int RDV_IN = 2;

  stageState_t state, stateNxt;
  logic        fire;
  logic        cOut;
  logic [RDV_IN-1:0] rdvIn;

  // the rendezvous sees the request and the inverted downstream acknowledge
  assign rdvIn = {upReq, ~dnAck};

  tpCElement #(.NIN(RDV_IN)) i_rdv (
    .clk  (clk),
    .rstN (rstN),
    .en   (state == ST_EMPTY),
    .in   (rdvIn),
    .fire (fire),
    .cOut (cOut)
  );

  always_comb begin
    stb.capture = fire;
    stb.pass    = (state == ST_FULL) && (dnAck == dnReq);
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_EMPTY: if (stb.capture)      stateNxt = ST_CAPT;
      ST_CAPT:  if (done.captureDone) stateNxt = ST_FULL;
      ST_FULL:  if (stb.pass)         stateNxt = ST_PASS;
      ST_PASS:  if (done.passDone)    stateNxt = ST_EMPTY;
      default:                        stateNxt = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_EMPTY;
      upAck <= 1'b0;
      dnReq <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_CAPT && done.captureDone) begin
        upAck <= ~upAck;
        dnReq <= ~dnReq;
      end
    end
  end

  // R2
  capture_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> (upReq != upAck) && (dnAck == dnReq));

  // R3
  ack_after_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upAck != $past(upAck)) |-> $past(stb.capture, 2));

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capture, stb.pass}));

  // R3
  phase_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FULL) |-> (cOut == upAck));

endmodule

// File: rtl/tpStageData.sv
module tpStageData
  import tpStagePkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageStrobe_t      stb,
  input  logic [DATA_W-1:0] upData,
  output stageDone_t        done,
  output logic [DATA_W-1:0] dnData
);

  logic              holdQ;
  logic [DATA_W-1:0] dataQ;
  logic              capDoneQ;
  logic              passDoneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ     <= 1'b0;
      dataQ     <= '0;
      capDoneQ  <= 1'b0;
      passDoneQ <= 1'b0;
    end else begin
      capDoneQ  <= stb.capture;
      passDoneQ <= stb.pass;
      if (stb.capture) begin
        holdQ <= 1'b1;
        dataQ <= upData;
      end else if (stb.pass) begin
        holdQ <= 1'b0;
      end
    end
  end

  always_comb begin
    done.captureDone = capDoneQ;
    done.passDone    = passDoneQ;
    dnData           = holdQ ? dataQ : upData;
  end

  // R2
  no_capture_while_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> !holdQ);

  // R5
  pass_only_when_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pass |-> holdQ);

endmodule

// File: rtl/tpStage.sv
module tpStage
  import tpStagePkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upReq,
  input  logic [DATA_W-1:0] upData,
  output logic              upAck,
  output logic              dnReq,
  output logic [DATA_W-1:0] dnData,
  input  logic              dnAck
);

  stageStrobe_t stb;
  stageDone_t   done;

  tpStageCtrl i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .upReq (upReq),
    .dnAck (dnAck),
    .done  (done),
    .stb   (stb),
    .upAck (upAck),
    .dnReq (dnReq)
  );

  tpStageData #(.DATA_W(DATA_W)) i_data (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .upData (upData),
    .done   (done),
    .dnData (dnData)
  );

  // R4
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((dnReq != dnAck) && $past(dnReq != dnAck)) |-> $stable(dnData));

endmodule

// File: tb/test_tpStage.sv
module test_tpStage;

  localparam int DATA_W   = 16;
  localparam int N_ITEMS  = 300;
  localparam int MAX_WAIT = 6;
  localparam int WDOG     = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              upReq = 1'b0;
  logic [DATA_W-1:0] upData = '0;
  logic              upAck;
  logic              dnReq;
  logic [DATA_W-1:0] dnData;
  logic              dnAck = 1'b0;

  int nChk = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  tpStage #(.DATA_W(DATA_W)) i_tpStage (
    .clk    (clk),
    .rstN   (rstN),
    .upReq  (upReq),
    .upData (upData),
    .upAck  (upAck),
    .dnReq  (dnReq),
    .dnData (dnData),
    .dnAck  (dnAck)
  );

  function automatic logic [DATA_W-1:0] itemVal(input int i);
    return DATA_W'((i * 40503) ^ 23130);
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic producer();
    for (int i = 0; i < N_ITEMS; i++) begin
      negs(int'($urandom_range(0, MAX_WAIT)));
      upData = itemVal(i);
      upReq  = ~upReq;
      do @(negedge clk); while (upAck != upReq);
    end
  endtask

  task automatic consumer();
    for (int i = 0; i < N_ITEMS; i++) begin
      int hold;
      while (dnReq == dnAck) @(negedge clk);
      // R8: order, no loss, no duplication
      check("R8", dnData, itemVal(i));
      hold = int'($urandom_range(0, MAX_WAIT));
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        check("R4", dnData, itemVal(i));
      end
      dnAck = ~dnAck;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    negs(4);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1", DATA_W'(upAck), '0);
    check("R1", DATA_W'(dnReq), '0);
    upData = 16'h1234;
    #1 check("R1", dnData, 16'h1234);

    // R3: rising request into empty stage
    @(negedge clk);
    upData = 16'hA5A5;
    upReq  = 1'b1;
    @(negedge clk);
    check("R3", DATA_W'(upAck), '0);
    @(negedge clk);
    check("R3", DATA_W'(upAck), 1);
    check("R3", DATA_W'(dnReq), 1);
    check("R3", dnData, 16'hA5A5);
    // R4: upstream data moves, held word does not
    upData = 16'h0F0F;
    #1 check("R4", dnData, 16'hA5A5);

    // R7 / R2: falling request while full
    @(negedge clk);
    upData = 16'hBEEF;
    upReq  = 1'b0;
    negs(4);
    check("R7", DATA_W'(upAck), 1);
    check("R4", dnData, 16'hA5A5);
    dnAck = 1'b1;
    negs(3);
    check("R7", DATA_W'(upAck), 1);
    @(negedge clk);
    check("R7", DATA_W'(upAck), 0);
    check("R2", DATA_W'(dnReq), 0);
    check("R7", dnData, 16'hBEEF);

    // R5: acknowledge reopens the register
    dnAck = 1'b0;
    @(negedge clk);
    upData = 16'hC0DE;
    #1 check("R5", dnData, 16'hC0DE);
    // R6: data change alone raises no acknowledge
    negs(3);
    upData = 16'h7777;
    negs(3);
    check("R6", DATA_W'(upAck), 0);
    check("R6", DATA_W'(dnReq), 0);
    check("R5", dnData, 16'h7777);

    // R8: random delays on both sides
    fork
      producer();
      consumer();
    join
    negs(2);
    check("R8", DATA_W'(upAck ^ upReq), 0);
    check("R8", DATA_W'(dnReq ^ dnAck), 0);
    finishRun();
  end

endmodule